// File: doc/BRIEF.md
# Serial Audio Transmitter with Clock Prescaler

The block turns a stream of parallel audio samples into a two-channel serial audio frame. It derives a master-clock rate from the system clock, either through an 8-bit programmable divider or directly. It then derives a bit clock from the master rate and produces a word-select line and a serial data line. Samples come from an upstream source over a valid/pop handshake. Each channel slot takes one sample in stereo mode. In mono mode one sample is sent on both channels.

All logic runs on the system clock. The master clock appears on its output as a one-cycle strobe per master period. The bit clock, word select and serial data are registered levels. A left/right state bit shows which channel the next fetched sample is for, so that software or an upstream engine can keep the channels aligned.

Top module: `aud_tx_serializer`

## Requirements
- R1: With the prescaler enabled and a prescaler value P of 2 or more, `mclk_o` pulses once every P system cycles. P = 0 and P = 1 give a pulse every cycle.
- R2: With the prescaler disabled, `mclk_o` pulses every system cycle, whatever the prescaler value.
- R3: `bclk_o` has a period of 4 master pulses and is high for the last two of them. `ws_o` and `sd_o` change only in the cycle in which `bclk_o` falls.
- R4: A frame is 64 bit periods: 32 for the left slot, then 32 for the right slot. `ws_o` is 0 for left and 1 for right, and it switches one bit period before the MSB of the slot it selects. The first bit period after reset carries the left MSB.
- R5: For a width field W from 1 to 32, a slot carries bits W-1 down to 0 of its sample, MSB first, and its remaining bits are 0. A field of 0, or a field above 32, acts as 32.
- R6: In stereo mode, successive samples go left, right, left, right, with one pop at the start of each slot.
- R7: In mono mode, one sample is popped at the start of the left slot and is sent in both slots of that frame. The left/right state does not change.
- R8: `lr_next_o` is 0 when the next sample is for the left channel. It inverts on every stereo pop.
- R9: A slot starts without a pop in two cases: no sample is valid, or the slot's channel differs from the left/right state. Such a slot carries all zeros and leaves the left/right state unchanged.
- R10: While `tx_en_i` is 0, `sd_o` is 0 and no sample is popped. The clocks and word select keep running.
- R11: `smp_pop_o` is a one-cycle pulse, asserted only while `smp_valid_i` and `tx_en_i` are 1. The sample is taken in that cycle.
- R12: During reset `sd_o`, `ws_o`, `bclk_o`, `smp_pop_o` and `lr_next_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| presc_en_i | input | 1 | Use the prescaler value |
| presc_i | input | 8 | Prescaler divisor |
| width_i | input | 6 | Sample width in bits |
| mono_i | input | 1 | Send one sample on both channels |
| tx_en_i | input | 1 | Transmit enable |
| smp_valid_i | input | 1 | A sample is available |
| smp_data_i | input | 32 | Sample word |
| smp_pop_o | output | 1 | Sample taken this cycle |
| lr_next_o | output | 1 | Channel of the next fetched sample (0 = left) |
| mclk_o | output | 1 | Master clock strobe |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select (0 = left) |
| sd_o | output | 1 | Serial data |

## Verification
The serial stream is decoded word by word and compared against sample words built from the width field. The patterns are:
- Full stereo and mono supply at widths 8, 12, 16, 20, 24 and 32, and with the out-of-range fields 0 and 40. These distinguish bit order, zero padding and the mono repeat from plain alternation.
- A stereo source that stops after three samples and resumes during a right slot. This shows that the mismatched left slot stays silent and does not pop, and that the right channel picks the stream up again.
- Prescaler values 0, 1, 2 and 3, and a bypass run with a nonzero value. These separate the divisor from the bypass through the measured strobe and bit-clock periods.
- A run with transmit disabled. It checks that the line stays silent and that nothing is popped.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } aud_ch_e;

  // Effective sample width: out-of-range fields fall back to the slot size.
  function automatic int unsigned eff_width(input int unsigned field,
                                            input int unsigned max_w);
    if (field == 0 || field > max_w) return max_w;
    return field;
  endfunction

  // Bit sent at position idx (0 = first) of a slot carrying a width-bit word.
  function automatic logic slot_bit(input logic [63:0] word,
                                    input int unsigned width,
                                    input int unsigned idx);
    if (idx < width) return word[width-1-idx];
    return 1'b0;
  endfunction

  // Terminal count of the master divider; 0 means a strobe every cycle.
  function automatic int unsigned div_limit(input logic en,
                                            input int unsigned presc);
    if (en && presc > 1) return presc - 1;
    return 0;
  endfunction

endpackage

// File: rtl/aud_mclk_div.sv
module aud_mclk_div #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             presc_en_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;

  always_comb begin
    lim    = PRE_W'(aud_tx_pkg::div_limit(presc_en_i, 32'(presc_i)));
    tick_o = (cnt_q >= lim);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PRE_W'(1);
  end

  // R1
  div_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_o && presc_en_i && presc_i > PRE_W'(1)) |=>
      (!tick_o || !$stable(presc_i) || !$stable(presc_en_i)));

  // R2
  bypass_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!presc_en_i && $past(!presc_en_i)) |-> tick_o);

endmodule

// File: rtl/aud_bit_timer.sv
module aud_bit_timer #(
  parameter int BCLK_DIV  = 4,
  parameter int SLOT_BITS = 32,
  localparam int BC_W  = $clog2(BCLK_DIV),
  localparam int POS_W = $clog2(2 * SLOT_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             fall_o,
  output logic [POS_W-1:0] nxt_pos_o
);
  logic [BC_W-1:0]  bcnt_q;
  logic [POS_W-1:0] pos_q;

  always_comb begin
    fall_o    = tick_i && (bcnt_q == BC_W'(BCLK_DIV - 1));
    bclk_o    = (bcnt_q >= BC_W'(BCLK_DIV / 2));
    nxt_pos_o = pos_q + POS_W'(1);
    ws_o      = pos_q[POS_W-1];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bcnt_q <= '0;
      pos_q  <= '0;
    end else if (tick_i) begin
      bcnt_q <= fall_o ? '0 : bcnt_q + BC_W'(1);
      if (fall_o) pos_q <= nxt_pos_o;
    end
  end

  // R3
  bclk_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(bclk_o) |-> $past(tick_i));

  // R4
  ws_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(ws_o) |-> $past(fall_o));

endmodule

// File: rtl/aud_sample_ctl.sv
module aud_sample_ctl #(
  parameter int SLOT_BITS = 32,
  parameter int WID_W     = 6,
  parameter int POS_W     = 6,
  localparam int B_W = POS_W - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 fall_i,
  input  logic [POS_W-1:0]     nxt_pos_i,
  input  logic                 tx_en_i,
  input  logic                 mono_i,
  input  logic [WID_W-1:0]     width_i,
  input  logic                 smp_valid_i,
  input  logic [SLOT_BITS-1:0] smp_data_i,
  output logic                 smp_pop_o,
  output logic                 lr_next_o,
  output logic                 sd_o
);
  import aud_tx_pkg::*;

  logic [POS_W-1:0]     slot_pos;
  logic [B_W-1:0]       bit_idx;
  aud_ch_e              ch;
  logic                 ch_start;
  logic                 claim;
  aud_ch_e              lr_q;
  logic [SLOT_BITS-1:0] word_q, word_nx;
  logic                 bit_nx;
  int unsigned          eff_w;

  always_comb begin
    slot_pos  = nxt_pos_i - POS_W'(1);
    bit_idx   = slot_pos[B_W-1:0];
    ch        = aud_ch_e'(slot_pos[POS_W-1]);
    ch_start  = fall_i && (bit_idx == '0);
    claim     = tx_en_i && ch_start &&
                (mono_i ? (ch == CH_LEFT) : (ch == lr_q));
    smp_pop_o = claim && smp_valid_i;
    lr_next_o = (lr_q == CH_RIGHT);

    word_nx = word_q;
    if (ch_start) begin
      if (!tx_en_i)                     word_nx = '0;
      else if (smp_pop_o)               word_nx = smp_data_i;
      else if (mono_i && ch == CH_RIGHT) word_nx = word_q;
      else                              word_nx = '0;
    end

    eff_w  = eff_width(32'(width_i), SLOT_BITS);
    bit_nx = tx_en_i && slot_bit(64'(word_nx), eff_w, 32'(bit_idx));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      word_q <= '0;
      sd_o   <= 1'b0;
      lr_q   <= CH_LEFT;
    end else if (fall_i) begin
      word_q <= word_nx;
      sd_o   <= bit_nx;
      if (smp_pop_o && !mono_i)
        lr_q <= (lr_q == CH_LEFT) ? CH_RIGHT : CH_LEFT;
    end
  end

  // R11
  pop_valid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    smp_pop_o |-> (smp_valid_i && tx_en_i));

  // R11
  pop_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    smp_pop_o |=> !smp_pop_o);

  // R10
  quiet_line_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (fall_i && !tx_en_i) |=> !sd_o);

  // R8
  lr_flip_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (smp_pop_o && !mono_i) |=> (lr_next_o != $past(lr_next_o)));

  // R9
  lr_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !smp_pop_o |=> $stable(lr_next_o));

  // R7
  mono_left_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (smp_pop_o && mono_i) |-> !nxt_pos_i[POS_W-1]);

endmodule

// File: rtl/aud_tx_serializer.sv
module aud_tx_serializer #(
  parameter int PRE_W     = 8,
  parameter int WID_W     = 6,
  parameter int SLOT_BITS = 32,
  parameter int BCLK_DIV  = 4,
  localparam int POS_W = $clog2(2 * SLOT_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 presc_en_i,
  input  logic [PRE_W-1:0]     presc_i,
  input  logic [WID_W-1:0]     width_i,
  input  logic                 mono_i,
  input  logic                 tx_en_i,
  input  logic                 smp_valid_i,
  input  logic [SLOT_BITS-1:0] smp_data_i,
  output logic                 smp_pop_o,
  output logic                 lr_next_o,
  output logic                 mclk_o,
  output logic                 bclk_o,
  output logic                 ws_o,
  output logic                 sd_o
);
  logic             mtick;
  logic             bfall;
  logic [POS_W-1:0] nxt_pos;

  aud_mclk_div #(.PRE_W(PRE_W)) u_div (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .presc_en_i (presc_en_i),
    .presc_i    (presc_i),
    .tick_o     (mtick)
  );

  aud_bit_timer #(.BCLK_DIV(BCLK_DIV), .SLOT_BITS(SLOT_BITS)) u_tmr (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tick_i    (mtick),
    .bclk_o    (bclk_o),
    .ws_o      (ws_o),
    .fall_o    (bfall),
    .nxt_pos_o (nxt_pos)
  );

  aud_sample_ctl #(.SLOT_BITS(SLOT_BITS), .WID_W(WID_W), .POS_W(POS_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .fall_i      (bfall),
    .nxt_pos_i   (nxt_pos),
    .tx_en_i     (tx_en_i),
    .mono_i      (mono_i),
    .width_i     (width_i),
    .smp_valid_i (smp_valid_i),
    .smp_data_i  (smp_data_i),
    .smp_pop_o   (smp_pop_o),
    .lr_next_o   (lr_next_o),
    .sd_o        (sd_o)
  );

  assign mclk_o = mtick;

endmodule

// File: tb/aud_tx_serializer_test.sv
module aud_tx_serializer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        presc_en = 1'b0;
  logic [7:0]  presc = 8'd0;
  logic [5:0]  width = 6'd16;
  logic        mono = 1'b0;
  logic        tx_en = 1'b0;
  logic        smp_valid;
  logic [31:0] smp_data;
  logic        smp_pop, lr_next, mclk, bclk, ws, sd;

  int unsigned idx = 0, lim = 0, kbase = 0;
  bit          resume = 0, mon_on = 0, done = 0;
  int          nchk = 0, nfail = 0;
  string       word_req = "";

  int unsigned cyc = 0, words = 0, bitk = 0;
  int unsigned last_tick = 0, last_fall = 0, mclk_gap = 0, bclk_gap = 0;
  bit          have_tick = 0, have_fall = 0, prev_bclk = 0;
  logic [31:0] acc_sd = '0, acc_ws = '0;

  always #5 clk = ~clk;

  function automatic logic [31:0] src_word(input int unsigned i);
    logic [7:0] b;
    b = i[7:0];
    return {b ^ 8'h96, b + 8'h3C, ~b, b * 8'd7 + 8'h11};
  endfunction

  assign smp_valid = (idx < lim);
  assign smp_data  = src_word(idx);

  aud_tx_serializer uut (
    .clk_i (clk), .rst_i (rst), .presc_en_i (presc_en), .presc_i (presc),
    .width_i (width), .mono_i (mono), .tx_en_i (tx_en),
    .smp_valid_i (smp_valid), .smp_data_i (smp_data),
    .smp_pop_o (smp_pop), .lr_next_o (lr_next), .mclk_o (mclk),
    .bclk_o (bclk), .ws_o (ws), .sd_o (sd)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned eff_w();
    if (width == 0 || width > 32) return 32;
    return 32'(width);
  endfunction

  function automatic logic [31:0] slotize(input logic [31:0] s);
    int unsigned e;
    logic [63:0] m;
    e = eff_w();
    m = (64'd1 << e) - 64'd1;
    return 32'((64'(s) & m) << (32 - e));
  endfunction

  // Expected slot word for decoded word n (even n = left slot).
  function automatic logic [31:0] exp_word(input int unsigned n);
    int unsigned si;
    bit ok;
    if (!tx_en) return '0;
    if (mono) begin
      si = n / 2; ok = (si < kbase);
    end else if (resume) begin
      if (n < 3)      begin si = n;     ok = 1; end
      else if (n < 5) begin si = 0;     ok = 0; end
      else            begin si = n - 2; ok = 1; end
    end else begin
      si = n; ok = (si < kbase);
    end
    return ok ? slotize(src_word(si)) : '0;
  endfunction

  // Expected word-select bits across word n: bit k sits at frame position k+1.
  function automatic logic [31:0] exp_ws(input int unsigned n);
    logic [31:0] r;
    r = '0;
    for (int j = 0; j < 32; j++) begin
      int unsigned p;
      p = (32 * n + j + 1) % 64;
      r = {r[30:0], (p >= 32)};
    end
    return r;
  endfunction

  // Consumer of the pop handshake: advance the source after the accepting edge.
  initial begin
    forever begin
      logic p;
      @(negedge clk);
      p = smp_pop;
      @(posedge clk);
      #1;
      if (p) idx++;
    end
  end

  // Monitor: strobe and bit-clock periods, serial word decode (R3 R4 R5).
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (mon_on) begin
        if (mclk) begin
          if (have_tick) mclk_gap = cyc - last_tick;
          last_tick = cyc; have_tick = 1;
        end
        if (prev_bclk && !bclk) begin
          if (have_fall) bclk_gap = cyc - last_fall;
          last_fall = cyc; have_fall = 1;
          acc_sd = {acc_sd[30:0], sd};
          acc_ws = {acc_ws[30:0], ws};
          bitk++;
          if (bitk % 32 == 0) begin
            check(acc_sd == exp_word(words), word_req, $sformatf("slot word %0d", words),
                  64'(acc_sd), 64'(exp_word(words)));
            check(acc_ws == exp_ws(words), "R4", $sformatf("ws pattern word %0d", words),
                  64'(acc_ws), 64'(exp_ws(words)));
            words++;
            if (resume && words == 4) begin
              // R9: left slot of frame 2 must stay silent, state points right
              check(lr_next == 1'b1, "R8", "lr after three stereo pops", 64'(lr_next), 64'd1);
              check(idx == 3, "R9", "pops before stall", 64'(idx), 64'd3);
              lim = 1000;
            end
          end
        end
        prev_bclk = bclk;
      end
    end
  end

  task automatic run_phase(input bit pen, input logic [7:0] p, input logic [5:0] w,
                           input bit mo, input bit te, input int unsigned k,
                           input bit res, input int unsigned nw, input string req);
    int unsigned d;
    int guard;
    mon_on = 0;
    @(negedge clk);
    rst = 1; presc_en = pen; presc = p; width = w; mono = mo; tx_en = te;
    idx = 0; lim = k; kbase = k; resume = res; word_req = req;
    repeat (3) @(negedge clk);
    // R12 reset state
    check({sd, ws, bclk, smp_pop, lr_next} == 5'b0, "R12", "outputs in reset",
          64'({sd, ws, bclk, smp_pop, lr_next}), 64'd0);
    words = 0; bitk = 0; have_tick = 0; have_fall = 0; prev_bclk = 0;
    mclk_gap = 0; bclk_gap = 0;
    rst = 0; mon_on = 1;
    guard = 0;
    while (words < nw && guard < 30000) begin
      @(negedge clk);
      guard++;
    end
    mon_on = 0;
    check(words >= nw, req, "phase completed", 64'(words), 64'(nw));
    d = (pen && p > 1) ? 32'(p) : 1;
    check(mclk_gap == d, pen ? "R1" : "R2", "master strobe period", 64'(mclk_gap), 64'(d));
    check(bclk_gap == 4 * d, "R3", "bit clock period", 64'(bclk_gap), 64'(4 * d));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R6 R5: stereo, width 16, divisor 1
    run_phase(1, 8'd1, 6'd16, 0, 1, 1000, 0, 8, "R6 R5");
    check(idx == 8, "R6", "stereo pops", 64'(idx), 64'd8);
    check(lr_next == 1'b0, "R8", "lr after even pops", 64'(lr_next), 64'd0);
    // R1 R5: divisor 3, width 24
    run_phase(1, 8'd3, 6'd24, 0, 1, 1000, 0, 6, "R5");
    // R2: bypass with nonzero value, width 32
    run_phase(0, 8'd7, 6'd32, 0, 1, 1000, 0, 6, "R5");
    // R1 R5: value 0 divides by 1; width field 0 acts as 32
    run_phase(1, 8'd0, 6'd0, 0, 1, 1000, 0, 4, "R5");
    // R5: field above 32 acts as 32; width 8
    run_phase(1, 8'd1, 6'd40, 0, 1, 1000, 0, 4, "R5");
    run_phase(1, 8'd1, 6'd8, 0, 1, 1000, 0, 4, "R5");
    // R7: mono, divisor 2
    run_phase(1, 8'd2, 6'd16, 1, 1, 1000, 0, 8, "R7");
    check(idx == 4, "R7", "mono pops per frame", 64'(idx), 64'd4);
    check(lr_next == 1'b0, "R7", "lr held in mono", 64'(lr_next), 64'd0);
    // R9: stereo stall after three samples, resume during a right slot
    run_phase(1, 8'd1, 6'd20, 0, 1, 3, 1, 10, "R9 R6");
    // R9 R7: mono underrun after two samples
    run_phase(1, 8'd1, 6'd12, 1, 1, 2, 0, 8, "R9 R7");
    check(idx == 2, "R9", "mono pops with stall", 64'(idx), 64'd2);
    check(lr_next == 1'b0, "R7", "lr after mono stall", 64'(lr_next), 64'd0);
    // R10: transmit disabled
    run_phase(1, 8'd2, 6'd16, 0, 0, 1000, 0, 4, "R10");
    check(idx == 0, "R10", "no pops when disabled", 64'(idx), 64'd0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule